// File: doc/BRIEF.md
# Four-Thread Fine-Grained Issue Scheduler

This block decides, every clock cycle, which of four hardware threads sends its next instruction into a shared single-issue pipeline. It can move to a different thread on any cycle at no cost. Among the threads that can issue, it picks the one that issued longest ago. A single one-hot select drives both the fetch stage and the thread-select stage, so both stages always work on the same thread.

Each thread has a small state machine. The machine tracks whether the thread may issue normally, is waiting out a load-to-use gap, may issue only speculatively behind a load whose hit or miss is not yet known, or is parked. A thread parks after a branch, multiply or divide, after a load miss, or while a trap is being handled. The block assumes that loads hit. After the load-to-use gap, the thread's next instruction may issue speculatively, but only when no thread can issue non-speculatively. If a miss report arrives later, the block raises a flush and a replay for that thread, and the thread waits until its load data returns. A trap raised late in the pipeline flushes the thread and keeps it out of selection until the trap is finished. A divide needs the single shared divider. A separate least-recently-granted order chooses which divide requester gets it, and the other threads keep issuing in the meantime.

Top module: `issue_sched`

## Requirements
- R1: `sel_o` has at most one bit set in every cycle, and `idle_o` is high exactly when no bit of `sel_o` is set.
- R2: Among the threads that can issue non-speculatively, the thread issued least recently wins. After reset the order from oldest to newest is thread 0, 1, 2, 3. The issuing thread becomes the most recent at the clock edge that ends its grant cycle.
- R3: Each thread's next instruction type is given as a 2-bit code in `thr_kind_i[2t+1:2t]`: 00 simple, 01 load, 10 branch or multiply, 11 divide. A thread is eligible only when its ready bit is high, its stall bit is low and its trap bit is low. Issuing a code 10 or 11 instruction removes the thread from selection until a cycle after its `long_done_i` bit is high.
- R4: After a thread issues a load (code 01), the thread cannot issue for the next two cycles. From the third cycle on, it may issue code 00 instructions speculatively.
- R5: A speculative issue happens only when no thread can issue non-speculatively, and `spec_o` is high in exactly those cycles.
- R6: A miss report (`res_vld_i` high, `res_hit_i` low, `res_tid_i` = t) for a thread in the speculative state raises `flush_o[t]` and `replay_o[t]` in the same cycle. The thread is not selected that cycle, and it stays out of selection until a cycle after `ld_ret_i[t]` is high. A hit report makes the thread issue non-speculatively from the next cycle.
- R7: When `trap_i[t]` is high, `flush_o[t]` is high in the same cycle and thread t is not selected. Thread t then stays out of selection until a cycle after `trap_done_i[t]` is high.
- R8: When no thread can issue, either normally or speculatively, `idle_o` is high and `sel_o` is zero.
- R9: A divide can issue only when `div_busy_i` is low and no divide issued in the previous cycle. Among the threads that would otherwise issue a divide, only the one granted the divider least recently may issue it. After reset that order is thread 0, 1, 2, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_ready_i | input | 4 | Thread has an instruction in its buffer |
| thr_stall_i | input | 4 | Thread blocked by a cache miss or resource conflict |
| thr_kind_i | input | 8 | Per-thread 2-bit predecode code of the next instruction |
| res_vld_i | input | 1 | Load hit/miss report valid |
| res_tid_i | input | 2 | Thread of the load report |
| res_hit_i | input | 1 | Load report is a hit |
| ld_ret_i | input | 4 | Missed load data has returned |
| long_done_i | input | 4 | Branch, multiply or divide has completed |
| trap_i | input | 4 | Trap detected in the memory stage |
| trap_done_i | input | 4 | Trap processing finished |
| div_busy_i | input | 1 | Shared divider is occupied |
| sel_o | output | 4 | One-hot thread select for the fetch and select stages |
| idle_o | output | 1 | No thread issues this cycle |
| spec_o | output | 1 | Issue this cycle is speculative |
| flush_o | output | 4 | Flush younger instructions of the thread |
| replay_o | output | 4 | Return the speculative instruction to the thread's buffer for reissue |

## Verification
Directed sequences run first. With all four threads ready and issuing simple instructions, the select must rotate 0, 1, 2, 3, 0. Any slip in the age order shows up as a wrong position in that rotation. A stalled oldest thread tells the eligibility mask apart from the age order. Single-thread runs measure the load gap cycle by cycle, the park after a long-latency instruction and the release one cycle after its completion. They also show that a trap holds the thread out and that a speculative thread yields to a normal one. Two competing divides check the spacing rule and the divider's own age order. A seeded random phase then mixes stalls, kinds, miss and hit reports, returns, traps and divider busy. It compares every output against a bench model built from the requirements.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // Predecode code of a thread's next instruction.
    typedef enum logic [1:0] {
        K_SIMPLE = 2'b00,
        K_LOAD   = 2'b01,
        K_LONG   = 2'b10,
        K_DIV    = 2'b11
    } kind_e;

    // Scheduling state of one thread.
    typedef enum logic [2:0] {
        TS_AVAIL  = 3'd0,
        TS_LDWAIT = 3'd1,
        TS_SPEC   = 3'd2,
        TS_LONG   = 3'd3,
        TS_MISS   = 3'd4,
        TS_TRAP   = 3'd5
    } tstate_e;

    // Events that move one thread's state.
    typedef struct packed {
        logic trap;
        logic trap_done;
        logic long_done;
        logic ld_ret;
        logic res_hit;
        logic res_miss;
    } tevt_t;

    function automatic logic parks_thread(kind_e k);
        return (k == K_LONG) || (k == K_DIV);
    endfunction

endpackage

// File: rtl/thread_ctx.sv
module thread_ctx
    import sched_pkg::*;
#(
    parameter int WAIT = 2,
    localparam int CW = $clog2(WAIT + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  kind_e   kind_i,
    input  tevt_t   evt_i,
    input  logic    issue_i,
    output tstate_e st_o
);

    tstate_e        st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (evt_i.trap) begin
            st_d = TS_TRAP;
        end else begin
            case (st_q)
                TS_AVAIL: begin
                    if (issue_i) begin
                        if (kind_i == K_LOAD) begin
                            st_d  = TS_LDWAIT;
                            cnt_d = CW'(WAIT);
                        end else if (parks_thread(kind_i)) begin
                            st_d = TS_LONG;
                        end
                    end
                end
                TS_LDWAIT: begin
                    if (cnt_q <= CW'(1)) st_d = TS_SPEC;
                    else                 cnt_d = cnt_q - CW'(1);
                end
                TS_SPEC: begin
                    if (evt_i.res_miss)     st_d = TS_MISS;
                    else if (evt_i.res_hit) st_d = TS_AVAIL;
                end
                TS_LONG:  if (evt_i.long_done) st_d = TS_AVAIL;
                TS_MISS:  if (evt_i.ld_ret)    st_d = TS_AVAIL;
                TS_TRAP:  if (evt_i.trap_done) st_d = TS_AVAIL;
                default:  st_d = TS_AVAIL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TS_AVAIL;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign st_o = st_q;

    // A trap always parks the thread at the next edge.
    assert_trap_park_R7: assert property (@(posedge clk) disable iff (rst)
        evt_i.trap |=> (st_q == TS_TRAP));

    // A normal load issue starts the wait window.
    assert_load_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_AVAIL && issue_i && kind_i == K_LOAD && !evt_i.trap)
            |=> (st_q == TS_LDWAIT));

    // Speculative state is only entered from the wait window.
    assert_spec_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == TS_SPEC && $past(st_q) != TS_SPEC) |-> ($past(st_q) == TS_LDWAIT));

endmodule

// File: rtl/lru_order.sv
module lru_order #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_i,
    input  logic          upd_i,
    input  logic [IW-1:0] upd_id_i,
    output logic [N-1:0]  gnt_o,
    output logic [IW-1:0] gnt_id_o,
    output logic          any_o
);

    // slot_q[0] is the oldest entry, slot_q[N-1] the most recent.
    logic [IW-1:0] slot_q [N];
    logic [IW-1:0] slot_d [N];
    logic [IW-1:0] pos;
    logic [N-1:0]  present;

    always_comb begin
        any_o    = 1'b0;
        gnt_id_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[slot_q[i]]) begin
                any_o    = 1'b1;
                gnt_id_o = slot_q[i];
            end
        end
        gnt_o = any_o ? (N'(1) << gnt_id_o) : '0;
    end

    always_comb begin
        pos = '0;
        for (int i = 0; i < N; i++) begin
            if (slot_q[i] == upd_id_i) pos = IW'(i);
        end
        for (int i = 0; i < N - 1; i++) begin
            slot_d[i] = (i < int'(pos)) ? slot_q[i] : slot_q[i+1];
        end
        slot_d[N-1] = upd_id_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) slot_q[i] <= IW'(i);
        end else if (upd_i) begin
            for (int i = 0; i < N; i++) slot_q[i] <= slot_d[i];
        end
    end

    always_comb begin
        present = '0;
        for (int i = 0; i < N; i++) present[slot_q[i]] = 1'b1;
    end

    // The order list always holds every id exactly once.
    assert_order_perm_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(present) == N);

    // The touched id becomes the most recent entry.
    assert_order_touch_R2: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> (slot_q[N-1] == $past(upd_id_i)));

endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import sched_pkg::*;
#(
    parameter int NT      = 4,
    parameter int LD_WAIT = 2,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NT-1:0]   thr_ready_i,
    input  logic [NT-1:0]   thr_stall_i,
    input  logic [2*NT-1:0] thr_kind_i,
    input  logic            res_vld_i,
    input  logic [TW-1:0]   res_tid_i,
    input  logic            res_hit_i,
    input  logic [NT-1:0]   ld_ret_i,
    input  logic [NT-1:0]   long_done_i,
    input  logic [NT-1:0]   trap_i,
    input  logic [NT-1:0]   trap_done_i,
    input  logic            div_busy_i,
    output logic [NT-1:0]   sel_o,
    output logic            idle_o,
    output logic            spec_o,
    output logic [NT-1:0]   flush_o,
    output logic [NT-1:0]   replay_o
);

    tstate_e        st [NT];
    kind_e          kd [NT];
    logic [NT-1:0]  base_ok, miss_now, div_req, ns_ok, sp_ok, is_div;
    logic [NT-1:0]  issue_req, div_gnt;
    logic [TW-1:0]  issue_id, div_gnt_id;
    logic           any_issue, div_any, div_free, div_fire, div_fire_q;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        tevt_t ev;
        logic  res_here;

        assign kd[t]    = kind_e'(thr_kind_i[2*t +: 2]);
        assign res_here = res_vld_i && (res_tid_i == TW'(t));

        always_comb begin
            ev.trap      = trap_i[t];
            ev.trap_done = trap_done_i[t];
            ev.long_done = long_done_i[t];
            ev.ld_ret    = ld_ret_i[t];
            ev.res_hit   = res_here & res_hit_i;
            ev.res_miss  = res_here & ~res_hit_i;
        end

        thread_ctx #(.WAIT(LD_WAIT)) u_ctx (
            .clk     (clk),
            .rst     (rst),
            .kind_i  (kd[t]),
            .evt_i   (ev),
            .issue_i (sel_o[t]),
            .st_o    (st[t])
        );

        assign base_ok[t]  = thr_ready_i[t] & ~thr_stall_i[t] & ~trap_i[t];
        assign miss_now[t] = ev.res_miss & (st[t] == TS_SPEC);
        assign is_div[t]   = (kd[t] == K_DIV);
        assign div_req[t]  = base_ok[t] & (st[t] == TS_AVAIL) & is_div[t];
        assign ns_ok[t]    = base_ok[t] & (st[t] == TS_AVAIL)
                           & (~is_div[t] | (div_free & div_gnt[t]));
        assign sp_ok[t]    = base_ok[t] & (st[t] == TS_SPEC)
                           & (kd[t] == K_SIMPLE) & ~miss_now[t];
    end

    // Speculative candidates only compete when no normal candidate exists.
    assign issue_req = (|ns_ok) ? ns_ok : sp_ok;
    assign spec_o    = ~(|ns_ok) & (|sp_ok);
    assign idle_o    = ~any_issue;
    assign flush_o   = trap_i | miss_now;
    assign replay_o  = miss_now;

    assign div_free  = ~div_busy_i & ~div_fire_q;
    assign div_fire  = any_issue & (|(sel_o & is_div));

    lru_order #(.N(NT)) u_issue_lru (
        .clk      (clk),
        .rst      (rst),
        .req_i    (issue_req),
        .upd_i    (any_issue),
        .upd_id_i (issue_id),
        .gnt_o    (sel_o),
        .gnt_id_o (issue_id),
        .any_o    (any_issue)
    );

    lru_order #(.N(NT)) u_div_lru (
        .clk      (clk),
        .rst      (rst),
        .req_i    (div_req),
        .upd_i    (div_fire),
        .upd_id_i (issue_id),
        .gnt_o    (div_gnt),
        .gnt_id_o (div_gnt_id),
        .any_o    (div_any)
    );

    always_ff @(posedge clk) begin
        if (rst) div_fire_q <= 1'b0;
        else     div_fire_q <= div_fire;
    end

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o) && (idle_o == (sel_o == '0)));

    assert_trap_masked_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_o & trap_i) == '0);

    assert_miss_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_o & replay_o) == '0);

    assert_div_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        div_fire |=> !div_fire);

    assert_div_winner_R9: assert property (@(posedge clk) disable iff (rst)
        div_fire |-> (div_any && div_gnt_id == issue_id));

    assert_spec_issues_R5: assert property (@(posedge clk) disable iff (rst)
        spec_o |-> !idle_o);

endmodule

// File: tb/issue_sched_test.sv
`timescale 1ns/1ps
module issue_sched_test;

    localparam int NT = 4;
    localparam int M_AV = 0, M_LW = 1, M_SP = 2, M_LG = 3, M_MS = 4, M_TR = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] rdy, stl, lret, ldone, trp, tdone;
    logic [7:0] kinds;
    logic       rv, rh, dbusy;
    logic [1:0] rtid;
    logic [3:0] sel_o, flush_o, replay_o;
    logic       idle_o, spec_o;

    int total = 0, bad = 0;
    bit finished = 0;

    // bench model
    int mst [4];
    int mcnt [4];
    int ord [4];
    int dord [4];
    bit mdivq;

    logic [3:0] cap_sel, cap_flush, cap_replay;
    logic       cap_idle, cap_spec;

    always #2 clk = ~clk;

    issue_sched uut (
        .clk(clk), .rst(rst), .thr_ready_i(rdy), .thr_stall_i(stl),
        .thr_kind_i(kinds), .res_vld_i(rv), .res_tid_i(rtid), .res_hit_i(rh),
        .ld_ret_i(lret), .long_done_i(ldone), .trap_i(trp), .trap_done_i(tdone),
        .div_busy_i(dbusy), .sel_o(sel_o), .idle_o(idle_o), .spec_o(spec_o),
        .flush_o(flush_o), .replay_o(replay_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int kind_of(int t);
        return int'(kinds[2*t +: 2]);
    endfunction

    function automatic int first_in(int lst [4], logic [3:0] m);
        for (int i = 0; i < NT; i++) if (m[lst[i]]) return lst[i];
        return -1;
    endfunction

    function automatic void touch(ref int lst [4], input int id);
        int p = 0;
        for (int i = 0; i < NT; i++) if (lst[i] == id) p = i;
        for (int i = p; i < NT - 1; i++) lst[i] = lst[i+1];
        lst[NT-1] = id;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            mst[t] = M_AV; mcnt[t] = 0; ord[t] = t; dord[t] = t;
        end
        mdivq = 0;
    endtask

    task automatic clear_inputs();
        rdy = '0; stl = '0; lret = '0; ldone = '0; trp = '0; tdone = '0;
        kinds = '0; rv = 0; rh = 0; rtid = '0; dbusy = 0;
    endtask

    // Called at a negedge with inputs applied; checks, advances model, waits for next negedge.
    task automatic step();
        logic [3:0] base, miss, dreq, ns, sp, esel, eflush;
        int dwin, pick;
        bit espec;
        #1;
        base = rdy & ~stl & ~trp;
        miss = '0; dreq = '0; ns = '0; sp = '0;
        for (int t = 0; t < NT; t++)
            miss[t] = rv && !rh && int'(rtid) == t && mst[t] == M_SP;
        for (int t = 0; t < NT; t++)
            dreq[t] = base[t] && mst[t] == M_AV && kind_of(t) == 3;
        dwin = first_in(dord, dreq);
        for (int t = 0; t < NT; t++) begin
            ns[t] = base[t] && mst[t] == M_AV &&
                    (kind_of(t) != 3 || (!dbusy && !mdivq && dwin == t));
            sp[t] = base[t] && mst[t] == M_SP && kind_of(t) == 0 && !miss[t];
        end
        espec = (ns == 0) && (sp != 0);
        pick = (ns != 0) ? first_in(ord, ns) : first_in(ord, sp);
        esel = (pick >= 0) ? (4'b1 << pick) : 4'b0;
        eflush = trp | miss;
        cap_sel = sel_o; cap_idle = idle_o; cap_spec = spec_o;
        cap_flush = flush_o; cap_replay = replay_o;
        chk("R2 sel", 32'(sel_o), 32'(esel));
        chk("R1 onehot", 32'($countones(sel_o) <= 1), 32'd1);
        chk("R8 idle", 32'(idle_o), 32'(pick < 0));
        chk("R5 spec", 32'(spec_o), 32'(espec));
        chk("R7 flush", 32'(flush_o), 32'(eflush));
        chk("R6 replay", 32'(replay_o), 32'(miss));
        for (int t = 0; t < NT; t++) begin
            if (trp[t]) mst[t] = M_TR;
            else case (mst[t])
                M_AV: if (pick == t) begin
                          if (kind_of(t) == 1) begin mst[t] = M_LW; mcnt[t] = 2; end
                          else if (kind_of(t) >= 2) mst[t] = M_LG;
                      end
                M_LW: if (mcnt[t] <= 1) mst[t] = M_SP; else mcnt[t]--;
                M_SP: if (rv && int'(rtid) == t) mst[t] = rh ? M_AV : M_MS;
                M_LG: if (ldone[t]) mst[t] = M_AV;
                M_MS: if (lret[t]) mst[t] = M_AV;
                M_TR: if (tdone[t]) mst[t] = M_AV;
                default: ;
            endcase
        end
        mdivq = (pick >= 0) && kind_of(pick) == 3;
        if (pick >= 0) touch(ord, pick);
        if (mdivq) touch(dord, pick);
        @(negedge clk);
    endtask

    task automatic do_reset();
        clear_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        #400000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear_inputs();
        @(negedge clk);
        do_reset();

        // reset state: nothing ready, idle (R8)
        step();
        chk("R8 reset idle", 32'(cap_idle), 32'd1);
        chk("R1 reset sel", 32'(cap_sel), 32'd0);

        // all ready, simple: rotation by age (R2)
        rdy = 4'hF;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R2 rotation", 32'(cap_sel), 32'(4'b1 << (i % 4)));
        end

        // oldest is thread 1 but stalled (R3)
        stl = 4'b0010;
        step();
        chk("R3 stall skip", 32'(cap_sel), 32'h4);
        stl = '0;

        // long-latency park and release (R3)
        rdy = 4'b0001; kinds = 8'b10;
        step();
        chk("R3 long issue", 32'(cap_sel), 32'h1);
        kinds = '0;
        step();
        chk("R3 long parked", 32'(cap_idle), 32'd1);
        ldone = 4'b0001;
        step();
        chk("R3 done cycle", 32'(cap_idle), 32'd1);
        ldone = '0;
        step();
        chk("R3 released", 32'(cap_sel), 32'h1);

        // load gap and speculative issue (R4, R5)
        rdy = 4'b0010; kinds = 8'b0000_0100;
        step();
        chk("R4 load issue", 32'(cap_sel), 32'h2);
        kinds = '0;
        step();
        chk("R4 gap 1", 32'(cap_idle), 32'd1);
        step();
        chk("R4 gap 2", 32'(cap_idle), 32'd1);
        step();
        chk("R4 spec sel", 32'(cap_sel), 32'h2);
        chk("R5 spec flag", 32'(cap_spec), 32'd1);
        rdy = 4'b0110;
        step();
        chk("R5 normal first", 32'(cap_sel), 32'h4);
        chk("R5 flag low", 32'(cap_spec), 32'd0);

        // miss: flush, replay, wait for return (R6)
        rdy = 4'b0010; rv = 1; rtid = 2'd1; rh = 0;
        step();
        chk("R6 flush", 32'(cap_flush), 32'h2);
        chk("R6 replay", 32'(cap_replay), 32'h2);
        chk("R6 not sel", 32'(cap_idle), 32'd1);
        rv = 0;
        step();
        chk("R6 waits", 32'(cap_idle), 32'd1);
        lret = 4'b0010;
        step();
        lret = '0;
        step();
        chk("R6 reissue", 32'(cap_sel), 32'h2);
        chk("R6 nonspec", 32'(cap_spec), 32'd0);

        // trap hold (R7)
        rdy = 4'b1000; trp = 4'b1000;
        step();
        chk("R7 trap flush", 32'(cap_flush), 32'h8);
        chk("R7 trap sel", 32'(cap_sel), 32'h0);
        trp = '0;
        step();
        chk("R7 held", 32'(cap_idle), 32'd1);
        tdone = 4'b1000;
        step();
        tdone = '0;
        step();
        chk("R7 released", 32'(cap_sel), 32'h8);

        // divider arbitration (R9)
        rdy = 4'b0101; kinds = 8'b00_11_00_11;
        step();
        chk("R9 first div", 32'(cap_sel), 32'h1);
        step();
        chk("R9 spacing", 32'(cap_idle), 32'd1);
        step();
        chk("R9 second div", 32'(cap_sel), 32'h4);
        rdy = '0; ldone = 4'hF;
        step();
        ldone = '0;
        step();
        rdy = 4'b0001; kinds = 8'b11; dbusy = 1;
        step();
        chk("R9 busy blocks", 32'(cap_idle), 32'd1);
        dbusy = 0;
        step();
        chk("R9 free grants", 32'(cap_sel), 32'h1);

        // seeded random phase
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            for (int t = 0; t < NT; t++) begin
                int r;
                rdy[t]   = ($urandom % 10) < 8;
                stl[t]   = ($urandom % 10) == 0;
                r = $urandom % 10;
                kinds[2*t +: 2] = (r < 5) ? 2'd0 : (r < 7) ? 2'd1 : (r < 8) ? 2'd2 : 2'd3;
                trp[t]   = (mst[t] != M_TR) && (($urandom % 40) == 0);
                tdone[t] = (mst[t] == M_TR) && (($urandom % 3) == 0);
                ldone[t] = (mst[t] == M_LG) && (($urandom % 3) == 0);
                lret[t]  = (mst[t] == M_MS) && (($urandom % 3) == 0);
            end
            dbusy = ($urandom % 5) == 0;
            rv    = ($urandom % 3) == 0;
            rtid  = 2'($urandom % 4);
            rh    = ($urandom % 10) < 7;
            step();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule